// File: doc/BRIEF.md
# SPI Serial Clock Prescaler and Slave Clock Filter

This block derives serial clock timing for an SPI master from the system clock. A 4-bit modulus, a factor-select bit and a divide-by-16 extension set the half-period of the serial clock. The block drives the serial clock level and raises a one-cycle strobe in the cycle before each clock edge. A data shifter uses that strobe to decide when to launch or sample a bit.

In slave mode the same modulus instead sets a stability count for the serial clock that arrives from outside. The incoming clock passes through a two-flop synchronizer. A new level is taken only after it has persisted for the programmed number of system clock cycles, so short glitches on the line are rejected. Whichever path is unused rests at the configured idle polarity.

Top module: `spi_sck_prescaler`

## Requirements
- R1: With fact_i=0 and div16_i=0, the sck_o period is 4×(pm_i+1) system clock cycles, and each level lasts 2×(pm_i+1) cycles.
- R2: With fact_i=0 and div16_i=1, the sck_o period is 64×(pm_i+1) system clock cycles.
- R3: With fact_i=1 and div16_i=0, the sck_o period is 2×(pm_i+1) system clock cycles. With pm_i=0, sck_o toggles on every clock.
- R4: With fact_i=1 and div16_i=1, the sck_o period is 32×(pm_i+1) system clock cycles.
- R5: In master mode, tick_o is high for exactly one cycle per half-period. It is high in the cycle whose closing clock edge toggles sck_o, and it is never high unless en_i=1 and master_i=1.
- R6: When en_i=0 or master_i=0, sck_o equals cpol_i from the next clock edge and tick_o stays low.
- R7: After en_i rises in master mode, the first half-period of sck_o has full length.
- R8: A change of pm_i, fact_i or div16_i leaves the half-period in progress unchanged. The new length applies from the next half-period boundary.
- R9: In slave mode with pm_i of 0 or 1, a level change on sck_i shows on sck_filt_o at the third clock edge after it.
- R10: In slave mode with pm_i=N≥2, a new sck_i level must hold for N cycles. A pulse shorter than N cycles never reaches sck_filt_o, and a held level appears at edge N+2.
- R11: When en_i=0 or master_i=1, sck_filt_o equals cpol_i from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| master_i | input | 1 | 1 selects master divider, 0 selects slave filter |
| pm_i | input | 4 | Modulus: divider scale or filter stability count |
| fact_i | input | 1 | Factor select: 0 for ×4 base, 1 for ×2 base |
| div16_i | input | 1 | Extra divide by 16 |
| cpol_i | input | 1 | Idle level of the serial clock |
| sck_i | input | 1 | Raw serial clock from the bus (slave mode) |
| sck_o | output | 1 | Generated serial clock (master mode) |
| tick_o | output | 1 | One-cycle strobe before each sck_o toggle |
| sck_filt_o | output | 1 | Synchronized and deglitched serial clock (slave mode) |

## Verification
Every cycle, the assertions check how the strobe relates to the clock edges: sck_o toggles after each strobe and holds while no strobe occurs in master mode. They also check that the strobe is gated by mode and that both outputs fall back to the idle polarity when their path is inactive. Only the bench scenarios can show the actual half-period lengths for each factor and divide combination. The same holds for the full first half-period after enable, the boundary at which a new configuration takes hold, and the filter latency and glitch rejection, because these depend on counted intervals rather than on single-cycle relations.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;
  localparam int unsigned PM_W_DEF    = 4;
  localparam int unsigned DIV_EXP_DEF = 4;
  localparam int unsigned SYNC_N_DEF  = 2;

  // half-period in system clocks
  function automatic int unsigned half_len(int unsigned pm, bit fact, bit div16,
                                           int unsigned div_exp);
    int unsigned h;
    h = (pm + 1) * (fact ? 1 : 2);
    if (div16) h = h << div_exp;
    return h;
  endfunction
endpackage

// File: rtl/spi_sck_sync.sv
module spi_sck_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[i] <= 1'b0;
          else         stg_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[i] <= 1'b0;
          else         stg_q[i] <= stg_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider #(
  parameter int unsigned PM_W    = 4,
  parameter int unsigned DIV_EXP = 4,
  localparam int unsigned CNT_W  = PM_W + 2 + DIV_EXP
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [PM_W-1:0] pm_i,
  input  logic            fact_i,
  input  logic            div16_i,
  input  logic            cpol_i,
  output logic            sck_o,
  output logic            tick_o
);
  logic [CNT_W-1:0] base, half_cfg, lim_q, cnt_q;
  logic             last;

  always_comb begin
    base     = CNT_W'(pm_i) + CNT_W'(1);
    half_cfg = fact_i ? base : (base << 1);
    if (div16_i) half_cfg = half_cfg << DIV_EXP;
  end

  assign last   = (cnt_q == lim_q - CNT_W'(1));
  assign tick_o = run_i & last;

  // length latched at each boundary; config changes apply to the next half
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= CNT_W'(2);
      sck_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      lim_q <= half_cfg;
      sck_o <= cpol_i;
    end else if (last) begin
      cnt_q <= '0;
      lim_q <= half_cfg;
      sck_o <= ~sck_o;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/spi_sck_filter.sv
module spi_sck_filter #(
  parameter int unsigned PM_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            sck_sync_i,
  input  logic [PM_W-1:0] pm_i,
  input  logic            cpol_i,
  output logic            sck_filt_o
);
  logic [PM_W-1:0] cnt_q;
  logic            accept;

  assign accept = (pm_i == '0) || (cnt_q == pm_i - PM_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      sck_filt_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q      <= '0;
      sck_filt_o <= cpol_i;
    end else if (sck_sync_i == sck_filt_o) begin
      cnt_q <= '0;
    end else if (accept) begin
      cnt_q      <= '0;
      sck_filt_o <= sck_sync_i;
    end else begin
      cnt_q <= cnt_q + PM_W'(1);
    end
  end
endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
  import spi_sck_pkg::*;
#(
  parameter int unsigned PM_W    = PM_W_DEF,
  parameter int unsigned DIV_EXP = DIV_EXP_DEF,
  parameter int unsigned SYNC_N  = SYNC_N_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            master_i,
  input  logic [PM_W-1:0] pm_i,
  input  logic            fact_i,
  input  logic            div16_i,
  input  logic            cpol_i,
  input  logic            sck_i,
  output logic            sck_o,
  output logic            tick_o,
  output logic            sck_filt_o
);
  logic run_m, run_s, sck_sync;

  assign run_m = en_i & master_i;
  assign run_s = en_i & ~master_i;

  spi_sck_divider #(.PM_W(PM_W), .DIV_EXP(DIV_EXP)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_m),
    .pm_i    (pm_i),
    .fact_i  (fact_i),
    .div16_i (div16_i),
    .cpol_i  (cpol_i),
    .sck_o   (sck_o),
    .tick_o  (tick_o)
  );

  spi_sck_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sck_i),
    .q_o    (sck_sync)
  );

  spi_sck_filter #(.PM_W(PM_W)) u_filt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_s),
    .sck_sync_i (sck_sync),
    .pm_i       (pm_i),
    .cpol_i     (cpol_i),
    .sck_filt_o (sck_filt_o)
  );
endmodule

// File: rtl/spi_sck_prescaler_chk.sv
module spi_sck_prescaler_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic master_i,
  input logic cpol_i,
  input logic sck_o,
  input logic tick_o,
  input logic sck_filt_o
);
  p_tick_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (en_i && master_i));

  p_tick_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (sck_o != $past(sck_o)));

  p_no_tick_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && master_i && !tick_o) |=> $stable(sck_o));

  p_idle_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && master_i) |=> (sck_o == $past(cpol_i)));

  p_filt_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && !master_i) |=> (sck_filt_o == $past(cpol_i)));
endmodule

bind spi_sck_prescaler spi_sck_prescaler_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .master_i   (master_i),
  .cpol_i     (cpol_i),
  .sck_o      (sck_o),
  .tick_o     (tick_o),
  .sck_filt_o (sck_filt_o)
);

// File: tb/tb_spi_sck_prescaler.sv
`timescale 1ns/1ps
module tb_spi_sck_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, master = 1'b1, fact = 1'b0, div16 = 1'b0, cpol = 1'b0, sck_in = 1'b0;
  logic [3:0] pm = 4'd0;
  logic       sck, tick, sck_filt;
  int         checks = 0, errors = 0;

  always #4 clk = ~clk;

  spi_sck_prescaler dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .master_i(master), .pm_i(pm),
    .fact_i(fact), .div16_i(div16), .cpol_i(cpol), .sck_i(sck_in),
    .sck_o(sck), .tick_o(tick), .sck_filt_o(sck_filt)
  );

  function automatic int exp_half(int p, bit f, bit d);
    return (p + 1) * (f ? 1 : 2) * (d ? 16 : 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure_half(output int n);
    logic prev;
    prev = sck;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sck == prev && n < 4000);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(sck == 1'b0, "R6 reset sck", sck, 0);
    chk(tick == 1'b0, "R6 reset tick", tick, 0);
    chk(sck_filt == 1'b0, "R11 reset filt", sck_filt, 0);
  endtask

  task automatic t_rate(int p, bit f, bit d, string req);
    int h, a, b, c, tk;
    @(negedge clk);
    en = 0; master = 1; pm = 4'(p); fact = f; div16 = d;
    @(negedge clk);
    en = 1;
    h = exp_half(p, f, d);
    measure_half(a);
    chk(a == h, "R7 first half", a, h);
    measure_half(b);
    measure_half(c);
    chk(b + c == 2 * h, req, b + c, 2 * h);
    tk = 0;
    for (int i = 0; i < 8 * h; i++) begin
      if (tick) tk++;
      @(negedge clk);
    end
    chk(tk == 8, "R5 ticks per 8 halves", tk, 8);
    en = 0;
  endtask

  task automatic t_idle();
    int tk;
    @(negedge clk);
    en = 0; master = 1; cpol = 1;
    tk = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (tick) tk++;
    end
    chk(sck == 1'b1, "R6 idle high", sck, 1);
    chk(tk == 0, "R6 no tick disabled", tk, 0);
    chk(sck_filt == 1'b1, "R11 filt idle in master", sck_filt, 1);
    en = 1; master = 0; pm = 4'd0;
    repeat (4) @(negedge clk);
    chk(sck == 1'b1, "R6 idle in slave", sck, 1);
    en = 0;
    cpol = 0;
    repeat (2) @(negedge clk);
    chk(sck == 1'b0, "R6 idle low", sck, 0);
  endtask

  task automatic t_change();
    int a, b, c;
    @(negedge clk);
    en = 0; master = 1; pm = 4'd1; fact = 0; div16 = 0;
    @(negedge clk);
    en = 1;
    measure_half(a);
    pm = 4'd3;
    measure_half(b);
    measure_half(c);
    chk(b == 4, "R8 half in progress kept", b, 4);
    chk(c == 8, "R8 new half length", c, 8);
    en = 0;
  endtask

  task automatic t_filter_pass(int p);
    int n;
    @(negedge clk);
    en = 0; master = 0; pm = 4'(p); cpol = 0; sck_in = 0;
    repeat (4) @(negedge clk);
    en = 1;
    repeat (4) @(negedge clk);
    sck_in = 1;
    n = 0;
    while (sck_filt == 1'b0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == 3, "R9 filter latency", n, 3);
    sck_in = 0;
    n = 0;
    while (sck_filt == 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == 3, "R9 filter latency fall", n, 3);
    en = 0;
  endtask

  task automatic t_filter_glitch(int p);
    int n, seen;
    @(negedge clk);
    en = 0; master = 0; pm = 4'(p); cpol = 0; sck_in = 0;
    repeat (4) @(negedge clk);
    en = 1;
    repeat (4) @(negedge clk);
    sck_in = 1;
    repeat (p - 1) @(negedge clk);
    sck_in = 0;
    seen = 0;
    for (int i = 0; i < p + 8; i++) begin
      @(negedge clk);
      if (sck_filt) seen++;
    end
    chk(seen == 0, "R10 short pulse rejected", seen, 0);
    sck_in = 1;
    n = 0;
    while (sck_filt == 1'b0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == p + 2, "R10 held level latency", n, p + 2);
    en = 0;
    sck_in = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rate(0, 0, 0, "R1 period pm0");
    t_rate(5, 0, 0, "R1 period pm5");
    t_rate(1, 0, 1, "R2 period div16");
    t_rate(0, 1, 0, "R3 period fastest");
    t_rate(6, 1, 0, "R3 period pm6");
    t_rate(2, 1, 1, "R4 period div16");
    t_rate(15, 0, 1, "R2 period slowest");
    t_idle();
    t_change();
    t_filter_pass(0);
    t_filter_pass(1);
    t_filter_glitch(5);
    t_filter_glitch(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule